// File: doc/BRIEF.md
# RS-485 Transceiver Direction Controller

This block drives the active-low direction pin of a half-duplex RS-485 transceiver that sits behind a UART transmitter. A low pin puts the transceiver in transmit. The pin goes low as soon as the transmitter has work, meaning it is shifting or its queue holds a character. It stays low until the line has been quiet for a programmed number of bit times after the last stop bit has left. Only then does it go high and hand the bus back to the receiver.

The delay is a 4-bit value that counts whole bit times, from 0 to 15. Software writes it through the upper nibble of a write-only register location. The write takes effect only while an enhanced-feature enable is set. When automatic mode is off, the pin follows a software-controlled transmit-request bit, and the turnaround counter stays cleared. The UART shifter, the baud generator and the FIFO are outside the block. They reach it as a one-cycle bit-time tick, a busy level and an empty flag.

Top module: `rs485_dir_ctrl`

## Requirements
- R1: After reset, `dir_n` is 1 (receive) and the stored delay is 0. With no write made, the first turnaround in auto mode releases the pin at once.
- R2: A cycle with `dly_wr`=1 and `enh_en`=1 loads `dly_wdata[7:4]` as the delay, in plain binary: value N means N bit times. Bits 3:0 are ignored.
- R3: A cycle with `dly_wr`=1 and `enh_en`=0 leaves the stored delay unchanged.
- R4: With `auto_en`=1, `dir_n` is 0 one clock after any cycle in which `tx_busy`=1 or `txq_empty`=0.
- R5: With a delay of N>0, `dir_n` stays 0 through the first N-1 ticks that follow the first idle cycle (`tx_busy`=0 and `txq_empty`=1). It rises exactly one clock after the clock that takes the N-th tick.
- R6: With a delay of 0, `dir_n` rises one clock after the first idle cycle, with no tick needed.
- R7: Ticks that arrive while the transmitter is not idle add nothing to the turnaround count.
- R8: If the transmitter leaves idle during a countdown, the count is discarded and `dir_n` stays 0. The next idle period needs the full N ticks again.
- R9: With `auto_en`=0, `dir_n` equals the inverse of `sw_rts` from the previous cycle, and the turnaround counter is held at zero.
- R10: Once released in auto mode, `dir_n` stays 1 while the transmitter remains idle, whatever the ticks do.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| bit_tick | input | 1 | One-cycle pulse at every bit-time boundary |
| tx_busy | input | 1 | Transmitter is shifting a character, start bit through stop bit |
| txq_empty | input | 1 | Transmit FIFO holds no characters |
| auto_en | input | 1 | Automatic direction mode enable |
| sw_rts | input | 1 | Software transmit request, used when auto mode is off |
| enh_en | input | 1 | Enhanced-feature enable that gates delay writes |
| dly_wr | input | 1 | Write strobe for the delay register location |
| dly_wdata | input | 8 | Write data; bits 7:4 carry the delay |
| dir_n | output | 1 | Transceiver direction, 0 = transmit, 1 = receive |

## Verification
The bench sweeps all sixteen delays. For each one it probes the pin right before and right after every tick of the countdown. This exposes an off-by-one count, which releases a tick early or late, and a counter that never stops at zero, which stalls the release for delay 0. Ticks are also sent while the transmitter is busy and then in the middle of a countdown. A design that keeps ticks from a busy period releases too early. So does one that resumes a cancelled count instead of starting again. Each delay write is followed by a write of a different value with the enable off. A missing gate on that write shows up as a wrong release time in the next countdown.

// File: rtl/rs485_dir_pkg.sv
package rs485_dir_pkg;
  localparam int DLY_W  = 4;
  localparam int DATA_W = 8;
  localparam int DLY_LSB = 4;
  typedef logic [DLY_W-1:0] dly_t;
endpackage

// File: rtl/rs485_dly_reg.sv
module rs485_dly_reg #(
  parameter int DATA_W = 8,
  parameter int FLD_W  = 4,
  parameter int FLD_LSB = 4
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr,
  input  logic              enh_en,
  input  logic [DATA_W-1:0] wdata,
  output logic [FLD_W-1:0]  dly
);
  localparam int FLD_MSB = FLD_LSB + FLD_W - 1;

  always_ff @(posedge clk) begin
    if (rst)               dly <= '0;
    else if (wr && enh_en) dly <= wdata[FLD_MSB:FLD_LSB];
  end

  // R3: a write made while the enhanced enable is clear must not change the field
  p_write_ignored_r3: assert property (@(posedge clk) disable iff (rst)
    (wr && !enh_en) |=> $stable(dly));
endmodule

// File: rtl/rs485_turn_cnt.sv
module rs485_turn_cnt #(
  parameter int CNT_W = 4
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             clr,
  input  logic             tick,
  input  logic [CNT_W-1:0] limit,
  output logic             done
);
  logic [CNT_W-1:0] cnt;

  // >= rather than == so that lowering the limit mid-count still ends the wait
  assign done = (cnt >= limit);

  always_ff @(posedge clk) begin
    if (rst || clr)          cnt <= '0;
    else if (tick && !done)  cnt <= cnt + 1'b1;
  end

  // R7: the count only moves on a tick
  p_no_count_without_tick_r7: assert property (@(posedge clk) disable iff (rst)
    (!clr && !tick) |=> $stable(cnt));
endmodule

// File: rtl/rs485_dir_ctrl.sv
module rs485_dir_ctrl
  import rs485_dir_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic              bit_tick,
  input  logic              tx_busy,
  input  logic              txq_empty,
  input  logic              auto_en,
  input  logic              sw_rts,
  input  logic              enh_en,
  input  logic              dly_wr,
  input  logic [DATA_W-1:0] dly_wdata,
  output logic              dir_n
);
  dly_t dly;
  logic idle;
  logic cnt_clr;
  logic cnt_done;

  assign idle = !tx_busy && txq_empty;
  // counter runs only while auto mode waits in transmit state on an idle line
  assign cnt_clr = !auto_en || !idle || dir_n;

  rs485_dly_reg #(
    .DATA_W (DATA_W),
    .FLD_W  (DLY_W),
    .FLD_LSB(DLY_LSB)
  ) dly_reg_i (
    .clk   (clk),
    .rst   (rst),
    .wr    (dly_wr),
    .enh_en(enh_en),
    .wdata (dly_wdata),
    .dly   (dly)
  );

  rs485_turn_cnt #(
    .CNT_W(DLY_W)
  ) turn_cnt_i (
    .clk  (clk),
    .rst  (rst),
    .clr  (cnt_clr),
    .tick (bit_tick),
    .limit(dly),
    .done (cnt_done)
  );

  always_ff @(posedge clk) begin
    if (rst)                   dir_n <= 1'b1;
    else if (!auto_en)         dir_n <= !sw_rts;
    else if (!idle)            dir_n <= 1'b0;
    else if (cnt_done)         dir_n <= 1'b1;
  end

  // R4: transmitter activity in auto mode drives the pin to transmit
  p_tx_on_activity_r4: assert property (@(posedge clk) disable iff (rst)
    (auto_en && !idle) |=> !dir_n);

  // R9: manual mode mirrors the software request
  p_follow_sw_r9: assert property (@(posedge clk) disable iff (rst)
    !auto_en |=> (dir_n == !$past(sw_rts)));

  // R5: an auto-mode release only happens out of an idle cycle
  p_release_needs_idle_r5: assert property (@(posedge clk) disable iff (rst)
    (auto_en && !dir_n) |=> (dir_n ? $past(idle) : 1'b1));
endmodule

// File: tb/rs485_dir_ctrl_tb_top.sv
module rs485_dir_ctrl_tb_top;
  logic clk = 1'b0;
  logic rst, bit_tick, tx_busy, txq_empty, auto_en, sw_rts, enh_en, dly_wr;
  logic [7:0] dly_wdata;
  logic dir_n;
  int n_vec = 0;
  int n_bad = 0;
  bit finished = 1'b0;

  always #10 clk = ~clk;

  rs485_dir_ctrl dut_i (
    .clk(clk), .rst(rst), .bit_tick(bit_tick), .tx_busy(tx_busy),
    .txq_empty(txq_empty), .auto_en(auto_en), .sw_rts(sw_rts),
    .enh_en(enh_en), .dly_wr(dly_wr), .dly_wdata(dly_wdata), .dir_n(dir_n)
  );

  task automatic cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic chk(input logic exp, input string req);
    n_vec++;
    if (dir_n !== exp) begin
      n_bad++;
      $display("FAIL %s: dir_n=%b expected %b at %0t", req, dir_n, exp, $time);
    end
  endtask

  task automatic wr_dly(input logic [3:0] v, input logic en);
    dly_wr = 1'b1; enh_en = en; dly_wdata = {v, ~v};
    cyc(1);
    dly_wr = 1'b0; enh_en = 1'b0;
  endtask

  task automatic pulse_tick();
    bit_tick = 1'b1; cyc(1); bit_tick = 1'b0;
  endtask

  // line goes idle now; walk d ticks checking the pin around each one
  task automatic countdown(input int d, input string req);
    tx_busy = 1'b0; txq_empty = 1'b1;
    cyc(1);
    chk(d == 0, (d == 0) ? "R6" : req);
    for (int k = 1; k <= d; k++) begin
      pulse_tick();
      chk(1'b0, req);
      cyc(1);
      chk(k == d, req);
    end
  endtask

  task automatic send_char();
    txq_empty = 1'b0; cyc(1);
    chk(1'b0, "R4");
    tx_busy = 1'b1; txq_empty = 1'b1;
    for (int j = 0; j < 12; j++) pulse_tick();  // R7: ticks during busy
    chk(1'b0, "R4");
  endtask

  initial begin
    rst = 1'b1; bit_tick = 0; tx_busy = 0; txq_empty = 1; auto_en = 0;
    sw_rts = 0; enh_en = 0; dly_wr = 0; dly_wdata = '0;
    cyc(3);
    chk(1'b1, "R1");
    rst = 1'b0; cyc(1);
    chk(1'b1, "R1");

    // R9: manual follow
    for (int j = 0; j < 4; j++) begin
      sw_rts = j[0]; cyc(1);
      chk(!sw_rts, "R9");
    end
    sw_rts = 1'b0;

    // R1: default delay is 0
    auto_en = 1'b1;
    send_char();
    countdown(0, "R1");

    // R2/R3/R5/R6/R7/R8/R10 sweep
    for (int d = 0; d < 16; d++) begin
      wr_dly(4'(d), 1'b1);          // R2
      wr_dly(4'(d ^ 5), 1'b0);      // R3: must be ignored
      send_char();
      countdown(d, (d == 0) ? "R6" : "R5");
      if (d >= 3) begin
        send_char();
        tx_busy = 1'b0;
        cyc(1); pulse_tick(); pulse_tick();
        chk(1'b0, "R8");
        tx_busy = 1'b1; cyc(1);
        chk(1'b0, "R8");
        countdown(d, "R8");
      end
      for (int j = 0; j < 5; j++) begin
        pulse_tick();
        chk(1'b1, "R10");
      end
    end

    // R9: disabling mid-countdown hands control to software
    wr_dly(4'd6, 1'b1);
    send_char();
    tx_busy = 1'b0; cyc(1); pulse_tick();
    auto_en = 1'b0; sw_rts = 1'b0; cyc(1);
    chk(1'b1, "R9");
    sw_rts = 1'b1; cyc(1);
    chk(1'b0, "R9");
    // R9: counter held while disabled, so re-enable needs full 6 ticks
    for (int j = 0; j < 8; j++) pulse_tick();
    auto_en = 1'b1;
    countdown(6, "R9");

    finished = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end

  initial begin
    for (int c = 0; c < 100000; c++) begin
      @(posedge clk);
      if (finished) break;
    end
    if (!finished) begin
      n_bad++;
      $display("FAIL watchdog: run did not complete");
      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
      $finish;
    end
  end
endmodule